// File: doc/BRIEF.md
# Two-Level Interrupt Arbiter for a Small Microcontroller Core

This block decides whether a small microcontroller core should take a hardware call into an interrupt service routine, and which source it should serve. Five request lines feed it: two external pins, two timer overflows and one serial flag. The core drives a machine-cycle phase counter that runs from 0 to 5, for the six states S1 to S6. On the clock edge where the phase reads 4 (S5), the block captures all five request lines into a sample register. At the same phase edge of the next machine cycle, it polls that sample. The core also supplies an enable register, a priority register and three status lines. The status lines mark the final machine cycle of the current instruction, a return-from-interrupt instruction, and a write to the enable or priority register.

A poll that wins produces a one-clock call request. The call request carries the vector address and the index of the selected source. The arbiter also sets the in-service flag for the level it granted. The block keeps one in-service flag for the low level and one for the high level. Only a return-from-interrupt clears a flag, and it clears the highest one that is set. The core performs the stack and datapath work itself.

The sequencing is a three-state machine. EMPTY is the state after reset, before any sample exists. ARMED means a sample is held and the next phase-4 edge is a poll. CALL is the single clock in which the call request is driven. The transitions are EMPTY to ARMED on the first phase-4 edge, ARMED to CALL on a granted poll, ARMED to ARMED on a blocked or empty poll (the sample is replaced by the fresh one), and CALL to ARMED on the next clock.

Top module: `mcu_irq_arbiter`

## Requirements
- R1: Request lines are captured only on a clock edge where the phase input equals 4 (S5; phases 0..5 encode S1..S6). A request that is present only between two such edges is never served.
- R2: A poll uses the sample captured at the previous phase-4 edge. A granted poll raises call_req for exactly one clock, starting right after the polling phase-4 edge. A request line that drops after capture is still served.
- R3: A source can win only if the global enable bit (enable bit 5) is set and its own enable bit is set. Source bits in both registers are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial.
- R4: A source whose priority bit is 1 is high level. Any enabled high-level request beats every low-level request, including one of lower index.
- R5: Within one level, the lowest source index wins (external 0 first, serial last).
- R6: call_src gives the winning index (0..4), and call_vec equals 0x0003 + 8 × index.
- R7: No call is issued when final_cyc is low at the polling edge.
- R8: No call is issued when reti_cyc or cfg_wr is high at the polling edge.
- R9: A low-level call needs both levels idle. A high-level call needs the high level idle. A high-level request therefore preempts a low-level routine, and nothing preempts a high-level routine.
- R10: busy_lvl (bit 1 high, bit 0 low) gains the granted level's bit with the call. It loses only its highest set bit, and only on a phase-4 edge with reti_cyc and final_cyc both high. A polling cycle without reti_cyc leaves it unchanged.
- R11: During and after reset, call_req and busy_lvl are 0, and the first phase-4 edge after reset only captures a sample and issues no call.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_phase | input | 3 | Machine-cycle state, 0..5 for S1..S6 |
| irq_req | input | 5 | Request lines, bit order as in R3 |
| en_reg | input | 6 | Per-source enables (bits 4:0) and global enable (bit 5) |
| pri_reg | input | 5 | Per-source level, 1 = high |
| final_cyc | input | 1 | Current machine cycle is the last of the instruction |
| reti_cyc | input | 1 | Current instruction is a return-from-interrupt |
| cfg_wr | input | 1 | Current instruction writes the enable or priority register |
| call_req | output | 1 | One-clock request for a hardware call |
| call_vec | output | 16 | Vector address of the selected source |
| call_src | output | 3 | Index of the selected source |
| busy_lvl | output | 2 | In-service flags, bit 1 high level, bit 0 low level |

## Verification
The bench aims at the capture window first. If a request pulse that falls between two phase-4 edges gets served, the sampler is transparent. If a request that drops right after capture is lost, the poll reads the pin instead of the sample. Tie and level cases check the winner order: a high-level serial request must beat a low-level external 0, which a plain index encoder would get wrong. The preemption chain is the other target. Low, then high, then a return must leave only the low flag. A design that clears both flags, or clears on a plain return, would then grant a low request that must stay blocked. A call pulse longer than one clock or a call with reti_cyc high would show up as a second grant or a stray call.

// File: rtl/mcu_irq_pkg.sv
`timescale 1ns/1ps
package mcu_irq_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_ARMED,
        ST_CALL
    } arb_state_t;

    function automatic logic [15:0] vec_addr(input int unsigned idx,
                                             input int unsigned base,
                                             input int unsigned stride);
        return 16'(base + idx * stride);
    endfunction

endpackage

// File: rtl/mcu_irq_sampler.sv
`timescale 1ns/1ps
module mcu_irq_sampler #(
    parameter int N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_en,
    input  logic [N_SRC-1:0] req_in,
    output logic [N_SRC-1:0] smp,
    output logic             smp_valid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp       <= '0;
            smp_valid <= 1'b0;
        end else if (latch_en) begin
            smp       <= req_in;
            smp_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/mcu_irq_pick.sv
`timescale 1ns/1ps
module mcu_irq_pick #(
    parameter int N_SRC = 5,
    parameter int IDX_W = 3
) (
    input  logic [N_SRC-1:0] smp,
    input  logic [N_SRC:0]   en_mask,
    input  logic [N_SRC-1:0] pri_mask,
    output logic             any_req,
    output logic [IDX_W-1:0] win_idx,
    output logic             win_hi
);

    logic [N_SRC-1:0] active;
    logic [N_SRC-1:0] hi_set;
    logic [N_SRC-1:0] lo_set;

    for (genvar g = 0; g < N_SRC; g++) begin : g_mask
        assign active[g] = smp[g] & en_mask[g] & en_mask[N_SRC];
        assign hi_set[g] = active[g] & pri_mask[g];
        assign lo_set[g] = active[g] & ~pri_mask[g];
    end

    always_comb begin
        any_req = |active;
        win_hi  = |hi_set;
        win_idx = '0;
        // scan downward so the lowest index is the last to be written
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (win_hi ? hi_set[i] : lo_set[i]) begin
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mcu_irq_level_track.sv
`timescale 1ns/1ps
module mcu_irq_level_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_lo,
    input  logic       set_hi,
    input  logic       clr_top,
    output logic [1:0] busy
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 2'b00;
        end else if (clr_top) begin
            if (busy[1]) begin
                busy[1] <= 1'b0;
            end else begin
                busy[0] <= 1'b0;
            end
        end else begin
            if (set_hi) busy[1] <= 1'b1;
            if (set_lo) busy[0] <= 1'b1;
        end
    end

endmodule

// File: rtl/mcu_irq_arbiter.sv
`timescale 1ns/1ps
module mcu_irq_arbiter
    import mcu_irq_pkg::*;
#(
    parameter int N_SRC        = 5,
    parameter int PHASES       = 6,
    parameter int SAMPLE_PHASE = 4,
    parameter int VEC_BASE     = 3,
    parameter int VEC_STRIDE   = 8,
    parameter int IDX_W        = $clog2(N_SRC),
    parameter int PH_W         = $clog2(PHASES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  mc_phase,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [N_SRC:0]   en_reg,
    input  logic [N_SRC-1:0] pri_reg,
    input  logic             final_cyc,
    input  logic             reti_cyc,
    input  logic             cfg_wr,
    output logic             call_req,
    output logic [15:0]      call_vec,
    output logic [IDX_W-1:0] call_src,
    output logic [1:0]       busy_lvl
);

    localparam logic [PH_W-1:0] POLL_PH = PH_W'(SAMPLE_PHASE);

    arb_state_t       state_q, state_d;
    logic             poll_edge;
    logic [N_SRC-1:0] smp;
    logic             smp_valid;
    logic             any_req;
    logic [IDX_W-1:0] win_idx;
    logic             win_hi;
    logic             level_ok;
    logic             grant;
    logic             ret_clear;
    logic [IDX_W-1:0] src_q;
    logic [15:0]      vec_q;

    assign poll_edge = (mc_phase == POLL_PH);

    mcu_irq_sampler #(.N_SRC(N_SRC)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_en  (poll_edge),
        .req_in    (irq_req),
        .smp       (smp),
        .smp_valid (smp_valid)
    );

    mcu_irq_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
        .smp      (smp),
        .en_mask  (en_reg),
        .pri_mask (pri_reg),
        .any_req  (any_req),
        .win_idx  (win_idx),
        .win_hi   (win_hi)
    );

    assign level_ok  = win_hi ? !busy_lvl[1] : !(busy_lvl[1] | busy_lvl[0]);
    assign grant     = poll_edge && (state_q == ST_ARMED) && smp_valid && any_req
                       && final_cyc && !reti_cyc && !cfg_wr && level_ok;
    assign ret_clear = poll_edge && reti_cyc && final_cyc;

    mcu_irq_level_track u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_lo  (grant && !win_hi),
        .set_hi  (grant && win_hi),
        .clr_top (ret_clear),
        .busy    (busy_lvl)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (poll_edge) state_d = ST_ARMED;
            ST_ARMED: if (grant)     state_d = ST_CALL;
            ST_CALL:                 state_d = ST_ARMED;
            default:                 state_d = ST_EMPTY;
        endcase
    end

    // state register and captured winner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            src_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (grant) begin
                src_q <= win_idx;
                vec_q <= vec_addr(32'(win_idx), VEC_BASE, VEC_STRIDE);
            end
        end
    end

    // outputs
    always_comb begin
        call_req = (state_q == ST_CALL);
        call_vec = vec_q;
        call_src = src_q;
    end

endmodule

// File: rtl/mcu_irq_arbiter_chk.sv
`timescale 1ns/1ps
module mcu_irq_arbiter_chk #(
    parameter int N_SRC        = 5,
    parameter int SAMPLE_PHASE = 4,
    parameter int IDX_W        = 3,
    parameter int PH_W         = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PH_W-1:0]  mc_phase,
    input logic             final_cyc,
    input logic             reti_cyc,
    input logic             cfg_wr,
    input logic             call_req,
    input logic [IDX_W-1:0] call_src,
    input logic [1:0]       busy_lvl
);

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> !call_req);

    assert_call_after_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> ($past(mc_phase) == PH_W'(SAMPLE_PHASE)));

    assert_final_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> $past(final_cyc));

    assert_no_reti_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (!$past(reti_cyc) && !$past(cfg_wr)));

    assert_high_not_preempted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> !$past(busy_lvl[1]));

    assert_busy_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (busy_lvl != $past(busy_lvl)));

    assert_busy_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(busy_lvl) & ~busy_lvl) != 2'b00) |-> $past(reti_cyc));

    assert_src_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (int'(call_src) < N_SRC));

endmodule

bind mcu_irq_arbiter mcu_irq_arbiter_chk #(
    .N_SRC        (N_SRC),
    .SAMPLE_PHASE (SAMPLE_PHASE),
    .IDX_W        (IDX_W),
    .PH_W         (PH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mc_phase  (mc_phase),
    .final_cyc (final_cyc),
    .reti_cyc  (reti_cyc),
    .cfg_wr    (cfg_wr),
    .call_req  (call_req),
    .call_src  (call_src),
    .busy_lvl  (busy_lvl)
);

// File: tb/mcu_irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module mcu_irq_arbiter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  phase = 3'd0;
    logic [4:0]  req = '0;
    logic [5:0]  en = '0;
    logic [4:0]  pri = '0;
    logic        fin = 1'b0;
    logic        reti = 1'b0;
    logic        wr = 1'b0;
    logic        call_req;
    logic [15:0] call_vec;
    logic [2:0]  call_src;
    logic [1:0]  busy;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            phase <= (phase == 3'd5) ? 3'd0 : phase + 3'd1;
        end
    end

    mcu_irq_arbiter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_phase  (phase),
        .irq_req   (req),
        .en_reg    (en),
        .pri_reg   (pri),
        .final_cyc (fin),
        .reti_cyc  (reti),
        .cfg_wr    (wr),
        .call_req  (call_req),
        .call_vec  (call_vec),
        .call_src  (call_src),
        .busy_lvl  (busy)
    );

    // fields: req[22:18] en[17:12] pri[11:7] fin[6] reti[5] wr[4] call[3] src[2:0]
    localparam logic [22:0] TBL [0:11] = '{
        {5'b00001, 6'b111111, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0},
        {5'b11110, 6'b111111, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1},
        {5'b11111, 6'b011111, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
        {5'b11111, 6'b111111, 5'b10000, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4},
        {5'b01100, 6'b111111, 5'b01100, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2},
        {5'b10001, 6'b110000, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4},
        {5'b00001, 6'b111111, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
        {5'b00001, 6'b111111, 5'b00000, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
        {5'b00001, 6'b111111, 5'b00000, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0},
        {5'b00000, 6'b111111, 5'b11111, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
        {5'b01000, 6'b111111, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3},
        {5'b00110, 6'b111111, 5'b00010, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // return at the negedge just after the next phase-4 edge
    task automatic step_s5();
        @(negedge clk);
        while (phase != 3'd4) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req = '0; fin = 1'b0; reti = 1'b0; wr = 1'b0;
        repeat (3) @(negedge clk);
        check(call_req == 1'b0, "R11 reset call_req", int'(call_req), 0);
        check(busy == 2'b00, "R11 reset busy", int'(busy), 0);
        rst_n = 1'b1;
    endtask

    // capture req with polling blocked, then poll it with final cycle high
    task automatic two_step(input logic [4:0] r, output logic got, output logic [2:0] src);
        req = r; fin = 1'b0;
        step_s5();
        fin = 1'b1;
        step_s5();
        got = call_req;
        src = call_src;
    endtask

    task automatic reti_step();
        req = '0; fin = 1'b0; reti = 1'b0;
        step_s5();
        reti = 1'b1; fin = 1'b1;
        step_s5();
        reti = 1'b0;
    endtask

    initial begin
        logic       got;
        logic [2:0] src;

        // vector table: R3 R4 R5 R6 R7 R8 R11
        for (int k = 0; k < 12; k++) begin
            logic [22:0] v;
            logic [1:0]  exp_busy;
            v = TBL[k];
            do_reset();
            req = v[22:18]; en = v[17:12]; pri = v[11:7];
            fin = v[6]; reti = v[5]; wr = v[4];
            step_s5();
            check(call_req == 1'b0, "R11 first S5 only captures", int'(call_req), 0);
            step_s5();
            check(call_req == v[3], "R3/R4/R7/R8 call decision", int'(call_req), int'(v[3]));
            if (v[3]) begin
                check(call_src == v[2:0], "R4/R5 winner", int'(call_src), int'(v[2:0]));
                check(call_vec == 16'(3 + 8 * int'(v[2:0])), "R6 vector",
                      int'(call_vec), 3 + 8 * int'(v[2:0]));
            end
            exp_busy = v[3] ? (pri[v[2:0]] ? 2'b10 : 2'b01) : 2'b00;
            check(busy == exp_busy, "R10 busy after poll", int'(busy), int'(exp_busy));
            @(negedge clk);
            check(call_req == 1'b0, "R2 single-clock pulse", int'(call_req), 0);
        end

        // R1/R2: request dropped after capture is still served
        do_reset();
        en = 6'b111111; pri = '0; fin = 1'b1;
        req = 5'b00100;
        step_s5();
        req = '0;
        step_s5();
        check(call_req == 1'b1 && call_src == 3'd2, "R2 served from sample",
              int'(call_src), 2);

        // R1: pulse between capture edges is missed
        do_reset();
        en = 6'b111111; pri = '0; fin = 1'b1;
        step_s5();
        req = 5'b00001;
        while (phase != 3'd3) @(negedge clk);
        req = '0;
        step_s5();
        check(call_req == 1'b0, "R1 missed pulse poll 1", int'(call_req), 0);
        step_s5();
        check(call_req == 1'b0, "R1 missed pulse poll 2", int'(call_req), 0);

        // R9/R10: preemption and return chain
        do_reset();
        en = 6'b111111; pri = 5'b00100;
        two_step(5'b00001, got, src);
        check(got == 1'b1 && src == 3'd0, "R9 low call", int'(src), 0);
        check(busy == 2'b01, "R10 low busy", int'(busy), 1);
        two_step(5'b00001, got, src);
        check(got == 1'b0, "R9 equal level blocked", int'(got), 0);
        two_step(5'b00100, got, src);
        check(got == 1'b1 && src == 3'd2, "R9 high preempts low", int'(src), 2);
        check(busy == 2'b11, "R10 both busy", int'(busy), 3);
        two_step(5'b00100, got, src);
        check(got == 1'b0, "R9 high not preempted", int'(got), 0);
        two_step(5'b00000, got, src);
        check(busy == 2'b11, "R10 plain return keeps busy", int'(busy), 3);
        reti_step();
        check(busy == 2'b01, "R10 return clears top only", int'(busy), 1);
        two_step(5'b00001, got, src);
        check(got == 1'b0, "R9 low still in service", int'(got), 0);
        reti_step();
        check(busy == 2'b00, "R10 second return", int'(busy), 0);
        two_step(5'b00001, got, src);
        check(got == 1'b1 && src == 3'd0, "R9 low after returns", int'(src), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule